// File: doc/BRIEF.md
# Queue Occupancy Statistics Monitor

This block sits beside an internal FIFO and observes it only through its push and pop strobes. From those strobes it rebuilds the queue's depth in a private counter. It then gathers four 64-bit statistics:

- the number of cycles the queue sat empty;
- the number of cycles in which the queue was touched;
- the highest depth ever reached, together with sticky full and overflow flags;
- the sum of the depth taken after every touch.

Software divides the sum by the touch count to obtain the average occupancy. No division is done in hardware.

The statistics are read through a plain register-read port that returns one 32-bit half per request. A clear pulse restarts every statistic without disturbing the depth tracking. The depth follows the FIFO, so it survives a clear. All control and read pins are plain strobes. The read port has no back-pressure: every accepted request produces exactly one result, one cycle later.

Top module: `qstat_monitor`

## Requirements
- R1: A cycle with `rd_en` high returns a result one cycle later, with `rd_valid` high. `rd_addr[4:3]` selects the statistic: 0 is idle cycles, 1 is the touch count, 2 is the peak status word and 3 is the depth sum. `rd_addr[2]` selects the upper (1) or lower (0) 32-bit half. The value returned is the one held before the edge that accepted the request. A cycle without `rd_en` gives `rd_valid` low the next cycle.
- R2: The idle statistic increases by one for every cycle in which the tracked depth is zero at the start of that cycle.
- R3: The touch count increases by one for every cycle with `push` or `pop` high. This includes a cycle with both strobes high and a pop that is ignored at depth zero.
- R4: On every cycle with `push` or `pop` high, the depth sum adds the depth that results from that cycle.
- R5: The peak status word holds zero in bits 63:48. It holds the peak depth in bits 47:32 and zero in bits 31:2. Bit 1 is a full flag that is set, and stays set, once the depth reaches `MAX_DEPTH`.
- R6: The peak field saturates at 0xFFFF. Bit 0 of the status word is an overflow flag that is set, and stays set, once the depth has gone above 0xFFFF.
- R7: A cycle with both `push` and `pop` high leaves the depth unchanged.
- R8: A pop while the depth is zero leaves the depth at zero. A push while the depth equals `MAX_DEPTH` leaves it at `MAX_DEPTH`.
- R9: A `clr` cycle zeroes, at the next edge, both counters, the sum, the peak and both flags. Strobes that arrive in that same cycle still move the depth but are not counted.
- R10: After synchronous reset, the depth, all statistics and `rd_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Monitored queue accepted an entry this cycle |
| pop | input | 1 | Monitored queue released an entry this cycle |
| clr | input | 1 | Restart all statistics |
| rd_en | input | 1 | Read request |
| rd_addr | input | 5 | Byte address of the requested 32-bit half |
| rd_valid | output | 1 | Read result present |
| rd_data | output | 32 | Read result |

## Verification
Two kinds of collision can fall into the same cycle. The first is a read request arriving on the same cycle as a push or pop that changes the statistic being read. The second is a clear arriving together with a push. The bench reads one half every cycle while it drives push bursts, pop bursts, combined strobes and clears. This makes a read of a statistic coincide again and again with an edge that changes it. A behavioural model answers each request from its pre-edge values. The model also keeps counting depth, but not statistics, on a clear cycle that carries a push. Each returned half is compared with the model on every clock.

// File: rtl/qstat_pkg.sv
package qstat_pkg;
  localparam int STAT_W  = 64;
  localparam int HALF_W  = 32;
  localparam int PEAK_W  = 16;
  localparam int ADDR_W  = 5;
  localparam logic [PEAK_W-1:0] PEAK_SAT = '1;

  typedef enum logic [1:0] {
    SEL_IDLE = 2'd0,
    SEL_TOUCH = 2'd1,
    SEL_PEAK = 2'd2,
    SEL_SUM = 2'd3
  } stat_sel_e;

  typedef struct packed {
    logic [STAT_W-1:0] idle;
    logic [STAT_W-1:0] touch;
    logic [STAT_W-1:0] sum;
    logic [PEAK_W-1:0] peak;
    logic              full;
    logic              ovf;
  } stats_t;
endpackage

// File: rtl/qstat_depth_tracker.sv
module qstat_depth_tracker #(
  parameter int MAX_DEPTH = 70000,
  localparam int DW = $clog2(MAX_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic [DW-1:0] depth,
  output logic [DW-1:0] depth_nxt,
  output logic          touch
);
  localparam logic [DW-1:0] CAP = DW'(MAX_DEPTH);

  always_comb begin
    depth_nxt = depth;
    if (push && !pop && depth != CAP)
      depth_nxt = depth + 1'b1;
    else if (pop && !push && depth != '0)
      depth_nxt = depth - 1'b1;
  end

  assign touch = push | pop;

  always_ff @(posedge clk) begin
    if (rst) depth <= '0;
    else     depth <= depth_nxt;
  end

  a_r7_both_hold: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> depth == $past(depth));
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && depth == '0) |=> depth == '0);
  a_r8_cap: assert property (@(posedge clk) disable iff (rst)
    depth <= CAP);
endmodule

// File: rtl/qstat_accum.sv
module qstat_accum
  import qstat_pkg::*;
#(
  parameter int MAX_DEPTH = 70000,
  localparam int DW = $clog2(MAX_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          touch,
  input  logic [DW-1:0] depth,
  input  logic [DW-1:0] depth_nxt,
  output stats_t        st
);
  logic [STAT_W-1:0] nxt_wide;
  assign nxt_wide = STAT_W'(depth_nxt);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st <= '0;
    end else begin
      if (depth == '0) st.idle <= st.idle + 1'b1;
      if (touch) begin
        st.touch <= st.touch + 1'b1;
        st.sum   <= st.sum + nxt_wide;
        if (nxt_wide > STAT_W'(PEAK_SAT)) begin
          st.peak <= PEAK_SAT;
          st.ovf  <= 1'b1;
        end else if (nxt_wide > STAT_W'(st.peak)) begin
          st.peak <= PEAK_W'(depth_nxt);
        end
        if (nxt_wide == STAT_W'(MAX_DEPTH)) st.full <= 1'b1;
      end
    end
  end

  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (st.idle == '0 && st.touch == '0 && st.sum == '0 &&
             st.peak == '0 && !st.full && !st.ovf));
  a_r3_touch_step: assert property (@(posedge clk) disable iff (rst)
    (!clr && touch) |=> st.touch == $past(st.touch) + 1'b1);
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (st.ovf && !clr) |=> st.ovf);
  a_r5_full_sticky: assert property (@(posedge clk) disable iff (rst)
    (st.full && !clr) |=> st.full);
endmodule

// File: rtl/qstat_readout.sv
module qstat_readout
  import qstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  stats_t            st,
  output logic              rd_valid,
  output logic [HALF_W-1:0] rd_data
);
  logic [STAT_W-1:0] words [4];
  logic [STAT_W-1:0] pick;
  stat_sel_e         sel;

  always_comb begin
    words[SEL_IDLE]  = st.idle;
    words[SEL_TOUCH] = st.touch;
    words[SEL_PEAK]  = {{PEAK_W{1'b0}}, st.peak, {(HALF_W-2){1'b0}}, st.full, st.ovf};
    words[SEL_SUM]   = st.sum;
    sel  = stat_sel_e'(rd_addr[4:3]);
    pick = words[sel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_addr[2] ? pick[STAT_W-1:HALF_W] : pick[HALF_W-1:0];
    end
  end

  a_r1_valid: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  a_r1_novalid: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
endmodule

// File: rtl/qstat_monitor.sv
module qstat_monitor
  import qstat_pkg::*;
#(
  parameter int MAX_DEPTH = 70000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        push,
  input  logic        pop,
  input  logic        clr,
  input  logic        rd_en,
  input  logic [4:0]  rd_addr,
  output logic        rd_valid,
  output logic [31:0] rd_data
);
  localparam int DW = $clog2(MAX_DEPTH + 1);

  logic [DW-1:0] depth, depth_nxt;
  logic          touch;
  stats_t        st;

  qstat_depth_tracker #(.MAX_DEPTH(MAX_DEPTH)) u_track (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .depth(depth), .depth_nxt(depth_nxt), .touch(touch)
  );

  qstat_accum #(.MAX_DEPTH(MAX_DEPTH)) u_acc (
    .clk(clk), .rst(rst), .clr(clr), .touch(touch),
    .depth(depth), .depth_nxt(depth_nxt), .st(st)
  );

  qstat_readout u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .st(st), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  a_r10_reset: assert property (@(posedge clk)
    rst |=> (depth == '0 && st == '0 && !rd_valid));
endmodule

// File: tb/qstat_monitor_tb.sv
module qstat_monitor_tb;
  localparam int MAXD = 70000;
  logic clk = 1'b0;
  logic rst = 1'b1, push = 1'b0, pop = 1'b0, clr = 1'b0, rd_en = 1'b1;
  logic [4:0] rd_addr = '0;
  logic rd_valid;
  logic [31:0] rd_data;

  qstat_monitor #(.MAX_DEPTH(MAXD)) u_dut (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .clr(clr),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string phase = "R10";
  longint unsigned m_idle, m_touch, m_sum;
  longint m_depth, m_peak;
  bit m_full, m_ovf, exp_valid;
  logic [31:0] exp_data;

  function automatic logic [63:0] model_word(input logic [1:0] s);
    logic [15:0] pk;
    pk = (m_peak > 65535) ? 16'hFFFF : 16'(m_peak);
    case (s)
      2'd0: return m_idle;
      2'd1: return m_touch;
      2'd2: return {16'h0, pk, 30'h0, m_full, m_ovf};
      default: return m_sum;
    endcase
  endfunction

  // Behavioural reference, updated at each edge from pre-edge state.
  always @(posedge clk) begin
    longint nd;
    logic [63:0] w;
    cyc++;
    if (rst) begin
      m_idle = 0; m_touch = 0; m_sum = 0; m_depth = 0; m_peak = 0;
      m_full = 0; m_ovf = 0; exp_valid = 0;
    end else begin
      exp_valid = rd_en;
      if (rd_en) begin
        w = model_word(rd_addr[4:3]);
        exp_data = rd_addr[2] ? w[63:32] : w[31:0];
      end
      nd = m_depth;
      if (push && !pop && m_depth < MAXD) nd = m_depth + 1;
      else if (pop && !push && m_depth > 0) nd = m_depth - 1;
      if (clr) begin
        m_idle = 0; m_touch = 0; m_sum = 0; m_peak = 0; m_full = 0; m_ovf = 0;
      end else begin
        if (m_depth == 0) m_idle++;
        if (push || pop) begin
          m_touch++;
          m_sum += longint'(nd);
          if (nd > m_peak) m_peak = nd;
          if (nd > 65535) m_ovf = 1;
          if (nd == MAXD) m_full = 1;
        end
      end
      m_depth = nd;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s (phase %s) cycle %0d: actual %h expected %h", req, phase, cyc, act, exp);
    end
  endtask

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (!rst && cyc > 1) begin
      check(rd_valid == exp_valid, "R1", {31'h0, rd_valid}, {31'h0, exp_valid});
      if (exp_valid && rd_valid) begin
        case (u_last_sel)
          2'd0: check(rd_data == exp_data, "R2", rd_data, exp_data);
          2'd1: check(rd_data == exp_data, "R3", rd_data, exp_data);
          2'd2: check(rd_data == exp_data, "R5", rd_data, exp_data);
          default: check(rd_data == exp_data, "R4", rd_data, exp_data);
        endcase
      end
    end
  end

  logic [1:0] u_last_sel = '0;
  always @(posedge clk) u_last_sel <= rd_addr[4:3];

  // Reader walks all eight halves continuously.
  always @(negedge clk) rd_addr <= rd_addr + 5'd4;

  always @(posedge clk) begin
    if (cyc > 190000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic drive(input bit pu, input bit po, input bit cl, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      push = pu; pop = po; clr = cl;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    phase = "R10"; drive(0, 0, 0, 16);
    phase = "R2";  drive(1, 0, 0, 5); drive(0, 0, 0, 8); drive(0, 1, 0, 3);
    phase = "R7";  drive(1, 1, 0, 10);
    phase = "R8";  drive(0, 1, 0, 6); drive(0, 0, 0, 8);
    phase = "R4";
    for (int i = 0; i < 40; i++) drive(i % 3 != 2, i % 3 == 2, 0, 1);
    phase = "R1";
    @(negedge clk); rd_en = 1'b0; drive(1, 0, 0, 6);
    @(negedge clk); rd_en = 1'b1; drive(0, 0, 0, 8);
    phase = "R9";  drive(1, 0, 1, 1); drive(1, 0, 0, 3); drive(0, 0, 1, 1); drive(0, 0, 0, 12);
    phase = "R6";  drive(1, 0, 0, MAXD + 10);
    phase = "R5";  drive(0, 0, 0, 12); drive(0, 1, 0, 5); drive(1, 1, 0, 4); drive(0, 0, 0, 12);
    phase = "R9";  drive(0, 0, 1, 1); drive(0, 0, 0, 12);
    phase = "R10"; @(negedge clk); rst = 1'b1; drive(0, 0, 0, 3);
    @(negedge clk); rst = 1'b0; drive(0, 0, 0, 12);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule